// File: doc/BRIEF.md
# Dual-Divisor UART Channel

A single asynchronous serial channel that moves one 8-bit character at a time in each direction. Transmit and receive keep separate bit-period divisors. Both divisors sit in one 32-bit baud configuration word, so the two directions can run at different rates. A character has one start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit.

The channel has a one-character holding register on each side. Its level controls select the parity, enable each direction, force a break on the line and drive RTS. An internal loopback control feeds the transmit stream straight into the receiver. Five status levels report the state of the holding registers and the receive errors, and they go to an interrupt controller. A synchronous clear input empties both directions without a full reset.

Top module: `uart_dual_div_chan`

## Requirements
- R1: The transmit divisor is taken from `baud_cfg[14:0]`. Every transmitted bit lasts transmit divisor + 1 clocks.
- R2: The receive divisor is taken from `baud_cfg[30:16]` and is independent of the transmit divisor. The receiver samples each incoming bit at the middle of a period of receive divisor + 1 clocks, and it consumes a parity bit when parity is enabled.
- R3: A transmitted frame is a low start bit, then data bits 0 to 7 in that order, then a high stop bit. The line idles high.
- R4: When `par_en` is 1, a parity bit follows data bit 7. With `par_even`=1 it makes the count of ones over data and parity even; with `par_even`=0 it makes that count odd.
- R5: `tx_rdy` is 0 from the write until the character moves into the shifter, one clock later. `tx_empty` stays 0 until the stop bit has ended. `tx_empty` implies `tx_rdy`.
- R6: While `tx_en` is 0, a pending character does not start and the line stays high.
- R7: While `tx_break` is 1, `txd` is driven low one clock later and no new character starts. Once the break is released, the pending character is sent.
- R8: While `loopback` is 1, `txd` is high one clock later and the transmit stream reaches the receiver in place of `rxd`.
- R9: When a character completes, `rx_rdy` rises and `rd_data` holds the character. A `rd_stb` pulse clears `rx_rdy`.
- R10: `frm_err` is 1 when the stop bit of the last received character was sampled low, and 0 when it was sampled high. The receiver then waits for the line to go high before it looks for a new start bit.
- R11: `rx_ovr` is set when a character completes while `rx_rdy` is still 1. The new character replaces the old one, and `rd_stb` clears `rx_ovr`.
- R12: While `rx_en` is 0, incoming characters are ignored and `rx_rdy` does not rise.
- R13: After reset, or one clock after a `sw_clr` pulse, `txd`=1, `tx_rdy`=1, `tx_empty`=1, `rx_rdy`=0 and `rx_ovr`=0.
- R14: `rts_out` follows `rts_req` with one clock of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous reset, active low |
| sw_clr | input | 1 | synchronous clear of both directions |
| baud_cfg | input | 32 | [14:0] transmit divisor, [30:16] receive divisor |
| par_en | input | 1 | parity bit present |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| tx_en | input | 1 | allows a new character to start |
| rx_en | input | 1 | allows reception |
| tx_break | input | 1 | hold the line low |
| rts_req | input | 1 | requested RTS level |
| loopback | input | 1 | internal loop from transmitter to receiver |
| wr_stb | input | 1 | write `wr_data` into the transmit holding register |
| wr_data | input | 8 | character to transmit |
| rd_stb | input | 1 | read acknowledge for the received character |
| rd_data | output | 8 | last received character |
| rx_rdy | output | 1 | received character waiting |
| tx_rdy | output | 1 | transmit holding register free |
| tx_empty | output | 1 | holding register and shifter both idle |
| rx_ovr | output | 1 | receive overrun |
| frm_err | output | 1 | framing error of the last character |
| txd | output | 1 | serial output |
| rxd | input | 1 | serial input |
| rts_out | output | 1 | registered RTS |

## Verification
The bench uses the default widths: 15-bit divisors, 8 data bits and the receive field at bit 16. It programs small divisors, from 3 to 11, so that every frame takes only a few dozen clocks. Different transmit and receive values in the same word show that the two fields are separate. Loopback needs equal divisors, and with them a full round trip fits in a short window. The bench drives `rxd` frames of its own at the receive rate, with good and bad stop bits, so that framing, overrun and the enable gating can each be hit on purpose.

// File: rtl/uart_chan_pkg.sv
// Shared types for the serial channel.
package uart_chan_pkg;

    // Receiver sequencing states.
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_WAIT_HI
    } rx_state_t;

endpackage

// File: rtl/uart_chan_tx.sv
// Transmit half: a holding register feeding a frame shifter.
// Assumes: div is stable while a character is on the line;
// a write while the holding register is full is dropped.
module uart_chan_tx #(
    parameter int DIV_W  = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [DIV_W-1:0]  div,
    input  logic              tx_en,
    input  logic              brk,
    input  logic              par_en,
    input  logic              par_even,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    output logic              ser,
    output logic              tx_rdy,
    output logic              tx_empty
);
    localparam int FRAME_W = DATA_W + 3;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    logic [DATA_W-1:0]  thr;
    logic               thr_full;
    logic               busy;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   bits_left;
    logic [DIV_W-1:0]   bcnt;
    logic               start_go;
    logic               par_bit;

    // Launch condition and parity of the pending character.
    always_comb begin
        start_go = !busy && thr_full && tx_en && !brk;
        par_bit  = par_even ? ^thr : ~^thr;
    end

    // Holding register, frame load and bit timing.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            thr       <= '0;
            thr_full  <= 1'b0;
            busy      <= 1'b0;
            frame     <= '1;
            bits_left <= '0;
            bcnt      <= '0;
        end else begin
            if (wr_stb && !thr_full) begin
                thr      <= wr_data;
                thr_full <= 1'b1;
            end
            if (start_go) begin
                thr_full  <= 1'b0;
                busy      <= 1'b1;
                frame     <= {1'b1, (par_en ? par_bit : 1'b1), thr, 1'b0};
                bits_left <= par_en ? CNT_W'(FRAME_W) : CNT_W'(FRAME_W - 1);
                bcnt      <= div;
            end else if (busy) begin
                if (bcnt == '0) begin
                    bcnt      <= div;
                    frame     <= {1'b1, frame[FRAME_W-1:1]};
                    bits_left <= bits_left - 1'b1;
                    if (bits_left == CNT_W'(1)) begin
                        busy <= 1'b0;
                    end
                end else begin
                    bcnt <= bcnt - 1'b1;
                end
            end
        end
    end

    // Serial level and status.
    always_comb begin
        ser      = busy ? frame[0] : 1'b1;
        tx_rdy   = !thr_full;
        tx_empty = !thr_full && !busy;
    end
endmodule

// File: rtl/uart_chan_rx.sv
// Receive half: start detection, mid-bit sampling and a one-character holding register.
// Assumes: line is already synchronised to clk; parity is consumed without being checked.
module uart_chan_rx
    import uart_chan_pkg::*;
#(
    parameter int DIV_W  = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [DIV_W-1:0]  div,
    input  logic              rx_en,
    input  logic              par_en,
    input  logic              line,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_rdy,
    output logic              rx_ovr,
    output logic              frm_err
);
    localparam int IDX_W = $clog2(DATA_W);

    rx_state_t          st;
    logic [DIV_W-1:0]   cnt;
    logic [IDX_W-1:0]   idx;
    logic [DATA_W-1:0]  sh;
    logic               done;

    // A character ends at the middle of its stop bit.
    always_comb done = rx_en && (st == RX_STOP) && (cnt == '0);

    // Bit sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            st  <= RX_IDLE;
            cnt <= '0;
            idx <= '0;
            sh  <= '0;
        end else if (!rx_en) begin
            st <= RX_IDLE;
        end else begin
            case (st)
                RX_IDLE: begin
                    if (!line) begin
                        cnt <= div >> 1;
                        st  <= RX_START;
                    end
                end
                RX_START: begin
                    if (cnt == '0) begin
                        if (line) begin
                            st <= RX_IDLE;
                        end else begin
                            cnt <= div;
                            idx <= '0;
                            st  <= RX_DATA;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                RX_DATA: begin
                    if (cnt == '0) begin
                        sh  <= {line, sh[DATA_W-1:1]};
                        cnt <= div;
                        if (idx == IDX_W'(DATA_W - 1)) begin
                            st <= par_en ? RX_PAR : RX_STOP;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                RX_PAR: begin
                    if (cnt == '0) begin
                        cnt <= div;
                        st  <= RX_STOP;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                RX_STOP: begin
                    if (cnt == '0) begin
                        st <= line ? RX_IDLE : RX_WAIT_HI;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                RX_WAIT_HI: begin
                    if (line) begin
                        st <= RX_IDLE;
                    end
                end
                default: st <= RX_IDLE;
            endcase
        end
    end

    // Holding register and flags.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rx_data <= '0;
            rx_rdy  <= 1'b0;
            rx_ovr  <= 1'b0;
            frm_err <= 1'b0;
        end else if (done) begin
            rx_data <= sh;
            frm_err <= !line;
            rx_rdy  <= 1'b1;
            rx_ovr  <= (rx_ovr || rx_rdy) && !rd_stb;
        end else if (rd_stb) begin
            rx_rdy <= 1'b0;
            rx_ovr <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_dual_div_chan.sv
// Channel top: splits the baud word, muxes break and loopback,
// synchronises rxd and registers txd and RTS.
// Assumes: rxd is asynchronous; controls are synchronous to clk.
module uart_dual_div_chan #(
    parameter int DIV_W      = 15,
    parameter int DATA_W     = 8,
    parameter int RX_DIV_LSB = 16,
    parameter int BAUD_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_clr,
    input  logic [BAUD_W-1:0] baud_cfg,
    input  logic              par_en,
    input  logic              par_even,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              tx_break,
    input  logic              rts_req,
    input  logic              loopback,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_rdy,
    output logic              tx_rdy,
    output logic              tx_empty,
    output logic              rx_ovr,
    output logic              frm_err,
    output logic              txd,
    input  logic              rxd,
    output logic              rts_out
);
    logic [DIV_W-1:0] tx_div;
    logic [DIV_W-1:0] rx_div;
    logic             cfg_unused;
    logic             tx_ser;
    logic             line_int;
    logic             rx_src;
    logic [1:0]       rx_sync;

    // Divisor fields and the internal line level.
    always_comb begin
        tx_div     = baud_cfg[DIV_W-1:0];
        rx_div     = baud_cfg[RX_DIV_LSB +: DIV_W];
        cfg_unused = ^{baud_cfg[BAUD_W-1], baud_cfg[RX_DIV_LSB-1:DIV_W]};
        line_int   = tx_break ? 1'b0 : tx_ser;
        rx_src     = loopback ? line_int : rxd;
    end

    // Output registers and the two-stage input synchroniser.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_clr) begin
            txd     <= 1'b1;
            rx_sync <= 2'b11;
            rts_out <= 1'b0;
        end else begin
            txd     <= loopback ? 1'b1 : line_int;
            rx_sync <= {rx_sync[0], rx_src};
            rts_out <= rts_req;
        end
    end

    uart_chan_tx #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (sw_clr),
        .div      (tx_div),
        .tx_en    (tx_en),
        .brk      (tx_break),
        .par_en   (par_en),
        .par_even (par_even),
        .wr_stb   (wr_stb),
        .wr_data  (wr_data),
        .ser      (tx_ser),
        .tx_rdy   (tx_rdy),
        .tx_empty (tx_empty)
    );

    uart_chan_rx #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (sw_clr),
        .div     (rx_div),
        .rx_en   (rx_en),
        .par_en  (par_en),
        .line    (rx_sync[1]),
        .rd_stb  (rd_stb),
        .rx_data (rd_data),
        .rx_rdy  (rx_rdy),
        .rx_ovr  (rx_ovr),
        .frm_err (frm_err)
    );
endmodule

// File: rtl/uart_dual_div_chan_chk.sv
// Property checker for the channel top, attached by bind.
module uart_dual_div_chan_chk (
    input logic clk,
    input logic rst_n,
    input logic sw_clr,
    input logic tx_en,
    input logic rx_en,
    input logic tx_break,
    input logic loopback,
    input logic wr_stb,
    input logic tx_rdy,
    input logic tx_empty,
    input logic rx_rdy,
    input logic rx_ovr,
    input logic txd
);
    // R5
    empty_implies_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> tx_rdy);

    // R6
    disabled_stays_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && tx_empty && !wr_stb) |=> tx_empty);

    // R7
    break_drives_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_break && !loopback && !sw_clr) |=> !txd);

    // R8
    loopback_idles_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loopback |=> txd);

    // R11
    overrun_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ovr) |-> $past(rx_rdy));

    // R12
    ready_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_rdy) |-> $past(rx_en));
endmodule

bind uart_dual_div_chan uart_dual_div_chan_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_clr   (sw_clr),
    .tx_en    (tx_en),
    .rx_en    (rx_en),
    .tx_break (tx_break),
    .loopback (loopback),
    .wr_stb   (wr_stb),
    .tx_rdy   (tx_rdy),
    .tx_empty (tx_empty),
    .rx_rdy   (rx_rdy),
    .rx_ovr   (rx_ovr),
    .txd      (txd)
);

// File: tb/test_uart_dual_div_chan.sv
// Directed bench: one task per scenario, each checking its own results.
module test_uart_dual_div_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_clr = 1'b0;
    logic [31:0] baud_cfg = '0;
    logic        par_en = 1'b0;
    logic        par_even = 1'b0;
    logic        tx_en = 1'b1;
    logic        rx_en = 1'b1;
    logic        tx_break = 1'b0;
    logic        rts_req = 1'b0;
    logic        loopback = 1'b0;
    logic        wr_stb = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        rd_stb = 1'b0;
    logic [7:0]  rd_data;
    logic        rx_rdy, tx_rdy, tx_empty, rx_ovr, frm_err, txd, rts_out;
    logic        rxd = 1'b1;

    int n_chk = 0;
    int n_err = 0;
    int txdiv = 7;
    int rxdiv = 11;

    always #5 clk = ~clk;

    uart_dual_div_chan i_uart_dual_div_chan (
        .clk(clk), .rst_n(rst_n), .sw_clr(sw_clr), .baud_cfg(baud_cfg),
        .par_en(par_en), .par_even(par_even), .tx_en(tx_en), .rx_en(rx_en),
        .tx_break(tx_break), .rts_req(rts_req), .loopback(loopback),
        .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb), .rd_data(rd_data),
        .rx_rdy(rx_rdy), .tx_rdy(tx_rdy), .tx_empty(tx_empty), .rx_ovr(rx_ovr),
        .frm_err(frm_err), .txd(txd), .rxd(rxd), .rts_out(rts_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_baud(input int t, input int r);
        txdiv = t;
        rxdiv = r;
        baud_cfg = {1'b0, 15'(r), 1'b0, 15'(t)};
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_char(input logic [7:0] d);
        @(negedge clk);
        wr_stb = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic read_char();
        @(negedge clk);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    // Waits for a start bit on txd and samples each bit at its centre.
    task automatic capture(output logic st, output logic [7:0] d,
                           output logic p, output logic sp);
        while (txd !== 1'b1) @(negedge clk);
        while (txd !== 1'b0) @(negedge clk);
        ticks(txdiv / 2);
        st = txd;
        for (int i = 0; i < 8; i++) begin
            ticks(txdiv + 1);
            d[i] = txd;
        end
        p = 1'b1;
        if (par_en) begin
            ticks(txdiv + 1);
            p = txd;
        end
        ticks(txdiv + 1);
        sp = txd;
    endtask

    // Drives one frame on rxd at the receive rate.
    task automatic send_rx(input logic [7:0] d, input logic use_par,
                           input logic pbit, input logic stop);
        @(negedge clk);
        rxd = 1'b0;
        ticks(rxdiv + 1);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            ticks(rxdiv + 1);
        end
        if (use_par) begin
            rxd = pbit;
            ticks(rxdiv + 1);
        end
        rxd = stop;
        ticks(rxdiv + 1);
        rxd = 1'b1;
        ticks(rxdiv + 1);
    endtask

    task automatic t_reset();
        ticks(1);
        chk("R13 reset txd", txd, 1);
        chk("R13 reset tx_rdy", tx_rdy, 1);
        chk("R13 reset tx_empty", tx_empty, 1);
        chk("R13 reset rx_rdy", rx_rdy, 0);
        chk("R13 reset rx_ovr", rx_ovr, 0);
    endtask

    task automatic t_bit_len();
        int lowlen = 0;
        set_baud(7, 11);
        write_char(8'h01);
        while (txd !== 1'b0) @(negedge clk);
        while (txd === 1'b0) begin
            lowlen++;
            @(negedge clk);
        end
        chk("R1 start bit length", lowlen, txdiv + 1);
        ticks(12 * (txdiv + 1));
        set_baud(3, 11);
        write_char(8'h01);
        lowlen = 0;
        while (txd !== 1'b0) @(negedge clk);
        while (txd === 1'b0) begin
            lowlen++;
            @(negedge clk);
        end
        chk("R1 start bit length small divisor", lowlen, 4);
        ticks(12 * 4);
    endtask

    task automatic t_frame();
        logic st, p, sp;
        logic [7:0] d;
        set_baud(9, 11);
        par_en = 1'b0;
        write_char(8'hA3);
        capture(st, d, p, sp);
        chk("R3 start bit", st, 0);
        chk("R3 data order", d, 8'hA3);
        chk("R3 stop bit", sp, 1);
        ticks(txdiv + 2);
        chk("R5 tx_empty after stop", tx_empty, 1);
    endtask

    task automatic t_parity();
        logic st, p, sp;
        logic [7:0] d;
        set_baud(5, 11);
        par_en = 1'b1;
        par_even = 1'b1;
        write_char(8'hA3);
        capture(st, d, p, sp);
        chk("R4 even parity 0xA3", p, 0);
        chk("R4 stop after parity", sp, 1);
        ticks(txdiv + 2);
        write_char(8'h07);
        capture(st, d, p, sp);
        chk("R4 even parity 0x07", p, 1);
        ticks(txdiv + 2);
        par_even = 1'b0;
        write_char(8'hA3);
        capture(st, d, p, sp);
        chk("R4 odd parity 0xA3", p, 1);
        chk("R4 data with parity", d, 8'hA3);
        ticks(txdiv + 2);
        par_en = 1'b0;
    endtask

    task automatic t_status();
        set_baud(7, 11);
        write_char(8'h3C);
        chk("R5 tx_rdy low after write", tx_rdy, 0);
        ticks(1);
        chk("R5 tx_rdy back after load", tx_rdy, 1);
        chk("R5 tx_empty low while sending", tx_empty, 0);
        ticks(12 * (txdiv + 1));
        chk("R5 tx_empty after frame", tx_empty, 1);
    endtask

    task automatic t_tx_disable();
        logic st, p, sp;
        logic [7:0] d;
        int hi = 1;
        tx_en = 1'b0;
        write_char(8'h5A);
        for (int i = 0; i < 40; i++) begin
            if (txd !== 1'b1) hi = 0;
            @(negedge clk);
        end
        chk("R6 line idle while disabled", hi, 1);
        chk("R6 char held", tx_rdy, 0);
        tx_en = 1'b1;
        capture(st, d, p, sp);
        chk("R6 held char sent on enable", d, 8'h5A);
        ticks(txdiv + 2);
    endtask

    task automatic t_break();
        logic st, p, sp;
        logic [7:0] d;
        int lo = 1;
        tx_break = 1'b1;
        write_char(8'hC5);
        for (int i = 0; i < 40; i++) begin
            if (txd !== 1'b0) lo = 0;
            @(negedge clk);
        end
        chk("R7 line low during break", lo, 1);
        chk("R7 no start during break", tx_rdy, 0);
        tx_break = 1'b0;
        capture(st, d, p, sp);
        chk("R7 char after break", d, 8'hC5);
        ticks(txdiv + 2);
    endtask

    task automatic t_rx_basic();
        set_baud(3, 11);
        send_rx(8'h3C, 1'b0, 1'b0, 1'b1);
        chk("R9 rx_rdy after char", rx_rdy, 1);
        chk("R2 received at rx rate", rd_data, 8'h3C);
        chk("R10 no framing error", frm_err, 0);
        read_char();
        chk("R9 read clears rx_rdy", rx_rdy, 0);
        par_en = 1'b1;
        send_rx(8'h81, 1'b1, 1'b0, 1'b1);
        chk("R2 received with parity bit", rd_data, 8'h81);
        read_char();
        par_en = 1'b0;
    endtask

    task automatic t_frame_err();
        send_rx(8'h66, 1'b0, 1'b0, 1'b0);
        chk("R10 framing error set", frm_err, 1);
        chk("R10 data still delivered", rd_data, 8'h66);
        read_char();
        send_rx(8'h99, 1'b0, 1'b0, 1'b1);
        chk("R10 framing error cleared by good char", frm_err, 0);
        chk("R10 next char after bad stop", rd_data, 8'h99);
        read_char();
    endtask

    task automatic t_overrun();
        send_rx(8'h11, 1'b0, 1'b0, 1'b1);
        chk("R11 no overrun on first", rx_ovr, 0);
        send_rx(8'h22, 1'b0, 1'b0, 1'b1);
        chk("R11 overrun set", rx_ovr, 1);
        chk("R11 newest char kept", rd_data, 8'h22);
        read_char();
        chk("R11 read clears overrun", rx_ovr, 0);
    endtask

    task automatic t_rx_disable();
        rx_en = 1'b0;
        send_rx(8'h5E, 1'b0, 1'b0, 1'b1);
        chk("R12 disabled receiver ignores char", rx_rdy, 0);
        rx_en = 1'b1;
    endtask

    task automatic t_loopback();
        int hi = 1;
        set_baud(6, 6);
        rxd = 1'b0;
        loopback = 1'b1;
        write_char(8'h96);
        for (int i = 0; i < 110; i++) begin
            if (txd !== 1'b1) hi = 0;
            @(negedge clk);
        end
        chk("R8 external line high in loopback", hi, 1);
        chk("R8 rx_rdy via loopback", rx_rdy, 1);
        chk("R8 looped data", rd_data, 8'h96);
        read_char();
        loopback = 1'b0;
        rxd = 1'b1;
        ticks(4);
    endtask

    task automatic t_soft_clear();
        set_baud(7, 11);
        send_rx(8'h44, 1'b0, 1'b0, 1'b1);
        tx_en = 1'b0;
        write_char(8'h12);
        chk("R13 pending before clear", tx_rdy, 0);
        @(negedge clk);
        sw_clr = 1'b1;
        @(negedge clk);
        sw_clr = 1'b0;
        chk("R13 clear tx_rdy", tx_rdy, 1);
        chk("R13 clear tx_empty", tx_empty, 1);
        chk("R13 clear rx_rdy", rx_rdy, 0);
        tx_en = 1'b1;
        ticks(30);
        chk("R13 dropped char not sent", txd, 1);
    endtask

    task automatic t_rts();
        @(negedge clk);
        rts_req = 1'b1;
        @(negedge clk);
        chk("R14 rts follows high", rts_out, 1);
        rts_req = 1'b0;
        @(negedge clk);
        chk("R14 rts follows low", rts_out, 0);
    endtask

    initial begin
        set_baud(7, 11);
        ticks(3);
        rst_n = 1'b1;
        t_reset();
        t_bit_len();
        t_frame();
        t_parity();
        t_status();
        t_tx_disable();
        t_break();
        t_rx_basic();
        t_frame_err();
        t_overrun();
        t_rx_disable();
        t_loopback();
        t_soft_clear();
        t_rts();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(200000 * 10);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule